// File: doc/BRIEF.md
# Inter-core mailbox bank

The block keeps sixteen 32-bit message words for a four-core cluster, four words owned by each core. Word j of core c sits at index c*4+j. Software on any core reaches the words through a simple register bus that has two 64-byte windows. Writing to the posting window ORs the write data into a word, so a sender can only add bits. Writing to the acknowledge window clears every bit that is one in the write data. Reading the acknowledge window returns the word's contents.

Each core also owns an 8-bit steering register. Its low nibble enables a normal interrupt (IRQ) for each of the core's four words. Its high nibble enables a fast interrupt (FIQ) for the same words. A word that holds any one bit raises a request, and the request is steered to FIQ when the FIQ enable is set, even if the IRQ enable is also set. The block drives the per-word IRQ and FIQ request arrays toward the interrupt router. It also drives a per-core OR of each array.

Top module: `mbox_bank`

## Requirements
- R1: While rst_ni is low, and after it is released, every word and every steering register reads zero, and all request and core outputs are low.
- R2: A write with addr_i = 0x80 + 4*(c*4+j) ORs wdata_i into word c*4+j. It leaves all other bits and all other words unchanged.
- R3: A write with addr_i = 0xC0 + 4*(c*4+j) clears each bit of word c*4+j where wdata_i is one. All other bits keep their value.
- R4: A read with addr_i = 0xC0 + 4*(c*4+j) places the contents of word c*4+j on rdata_o in the cycle after the request. rdata_o then holds that value until the next read.
- R5: A read anywhere in the posting window 0x80-0xBF returns zero.
- R6: The steering register of core c is at 0x50 + 4*c. A write stores wdata_i[7:0]. A read returns that byte with bits 31:8 at zero.
- R7: When word c*4+j is non-zero and steering bit 4+j of core c is set, fiq_req_o[c*4+j] is high and irq_req_o[c*4+j] is low, whatever the value of bit j.
- R8: When word c*4+j is non-zero, steering bit j of core c is set and bit 4+j is clear, irq_req_o[c*4+j] is high.
- R9: A zero word raises no request. A non-zero word whose two enable bits are both clear also raises no request.
- R10: irq_o[c] is the OR of irq_req_o[c*4+3:c*4]. fiq_o[c] is the OR of fiq_req_o[c*4+3:c*4].
- R11: A write to an address outside the steering, posting and acknowledge windows changes no state. A read from such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access in this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_req_o | output | 16 | IRQ request for each word, index c*4+j |
| fiq_req_o | output | 16 | FIQ request for each word, index c*4+j |
| irq_o | output | 4 | Per-core OR of the IRQ requests |
| fiq_o | output | 4 | Per-core OR of the FIQ requests |

## Verification
The bound checker checks four properties on every cycle. No word sees IRQ and FIQ together. A request never comes from a zero word. A word loses bits only through an acknowledge write, and after such a write the bits that were written are gone. A steering write takes effect in the next cycle.

Only the bench scenarios can show the rest: the exact OR result of repeated posts, the read-back values, the zero reads of the posting window and of unmapped addresses, the per-core OR outputs, and the fact that writes outside the windows change nothing.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned NUM_CORES     = 4;
  localparam int unsigned MBOX_PER_CORE = 4;
  localparam int unsigned DATA_W        = 32;
  localparam int unsigned ADDR_W        = 8;
  localparam int unsigned NUM_MBOX      = NUM_CORES * MBOX_PER_CORE;
  localparam int unsigned CTRL_W        = 2 * MBOX_PER_CORE;

  // window bases; each is aligned to its own window size
  localparam logic [31:0] CTRL_BASE = 32'h50;
  localparam logic [31:0] SET_BASE  = 32'h80;
  localparam logic [31:0] CLR_BASE  = 32'hC0;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CTRL = 2'd1,
    RD_MBOX = 2'd2
  } rd_kind_e;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int unsigned N_CORES = mbox_pkg::NUM_CORES,
  parameter int unsigned N_MBOX  = mbox_pkg::NUM_MBOX,
  parameter int unsigned AW      = mbox_pkg::ADDR_W
) (
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [AW-1:0]              addr_i,
  output logic [N_MBOX-1:0]          set_sel_o,
  output logic [N_MBOX-1:0]          clr_sel_o,
  output logic [N_CORES-1:0]         ctrl_sel_o,
  output rd_kind_e                   rd_kind_o,
  output logic [$clog2(N_MBOX)-1:0]  mbox_idx_o,
  output logic [$clog2(N_CORES)-1:0] core_idx_o
);
  localparam int unsigned IDX_W  = $clog2(N_MBOX);
  localparam int unsigned CORE_W = $clog2(N_CORES);
  localparam logic [31:0] CTRL_END = CTRL_BASE + 32'(4 * N_CORES);
  localparam logic [31:0] SET_END  = SET_BASE + 32'(4 * N_MBOX);
  localparam logic [31:0] CLR_END  = CLR_BASE + 32'(4 * N_MBOX);

  logic [31:0] addr_ext;
  logic        in_ctrl, in_set, in_clr, wr;

  assign addr_ext   = 32'(addr_i);
  assign in_ctrl    = (addr_ext >= CTRL_BASE) && (addr_ext < CTRL_END);
  assign in_set     = (addr_ext >= SET_BASE)  && (addr_ext < SET_END);
  assign in_clr     = (addr_ext >= CLR_BASE)  && (addr_ext < CLR_END);
  assign wr         = req_i && we_i;
  // bases are window-aligned, so the index is a plain bit slice
  assign mbox_idx_o = addr_i[IDX_W+1:2];
  assign core_idx_o = addr_i[CORE_W+1:2];

  for (genvar i = 0; i < N_MBOX; i++) begin : g_mbox_sel
    assign set_sel_o[i] = wr && in_set && (mbox_idx_o == IDX_W'(i));
    assign clr_sel_o[i] = wr && in_clr && (mbox_idx_o == IDX_W'(i));
  end

  for (genvar c = 0; c < N_CORES; c++) begin : g_ctrl_sel
    assign ctrl_sel_o[c] = wr && in_ctrl && (core_idx_o == CORE_W'(c));
  end

  always_comb begin
    if (in_ctrl)     rd_kind_o = RD_CTRL;
    else if (in_clr) rd_kind_o = RD_MBOX;
    else             rd_kind_o = RD_NONE;
  end
endmodule

// File: rtl/mbox_word.sv
module mbox_word #(
  parameter int unsigned DW = mbox_pkg::DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o,
  output logic          nz_o
);
  logic [DW-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= '0;
    else if (set_i) q <= q | wdata_i;
    else if (clr_i) q <= q & ~wdata_i;
  end

  assign q_o  = q;
  assign nz_o = |q;
endmodule

// File: rtl/mbox_steer.sv
module mbox_steer #(
  parameter int unsigned M = mbox_pkg::MBOX_PER_CORE
) (
  input  logic [M-1:0]   nz_i,
  input  logic [2*M-1:0] ctrl_i,
  output logic [M-1:0]   irq_req_o,
  output logic [M-1:0]   fiq_req_o,
  output logic           irq_o,
  output logic           fiq_o
);
  logic [M-1:0] irq_en, fiq_en;

  assign irq_en    = ctrl_i[M-1:0];
  assign fiq_en    = ctrl_i[2*M-1:M];
  // FIQ wins when both enables are set
  assign fiq_req_o = nz_i & fiq_en;
  assign irq_req_o = nz_i & irq_en & ~fiq_en;
  assign irq_o     = |irq_req_o;
  assign fiq_o     = |fiq_req_o;
endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
  import mbox_pkg::*;
#(
  parameter int unsigned N_CORES = mbox_pkg::NUM_CORES,
  parameter int unsigned M       = mbox_pkg::MBOX_PER_CORE,
  parameter int unsigned DW      = mbox_pkg::DATA_W,
  parameter int unsigned AW      = mbox_pkg::ADDR_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  output logic [N_CORES*M-1:0] irq_req_o,
  output logic [N_CORES*M-1:0] fiq_req_o,
  output logic [N_CORES-1:0]   irq_o,
  output logic [N_CORES-1:0]   fiq_o
);
  localparam int unsigned N_MBOX = N_CORES * M;
  localparam int unsigned CW     = 2 * M;
  localparam int unsigned IDX_W  = $clog2(N_MBOX);
  localparam int unsigned CORE_W = $clog2(N_CORES);

  logic [N_MBOX-1:0]     set_sel, clr_sel, nz;
  logic [N_CORES-1:0]    ctrl_sel;
  rd_kind_e              rd_kind;
  logic [IDX_W-1:0]      mbox_idx;
  logic [CORE_W-1:0]     core_idx;
  logic [N_MBOX*DW-1:0]  mbox_flat;
  logic [N_CORES*CW-1:0] ctrl_flat;
  logic [CW-1:0]         ctrl_q [N_CORES];
  logic [DW-1:0]         rd_d, rdata_q;

  mbox_decode #(.N_CORES(N_CORES), .N_MBOX(N_MBOX), .AW(AW)) u_decode (
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .set_sel_o  (set_sel),
    .clr_sel_o  (clr_sel),
    .ctrl_sel_o (ctrl_sel),
    .rd_kind_o  (rd_kind),
    .mbox_idx_o (mbox_idx),
    .core_idx_o (core_idx)
  );

  for (genvar i = 0; i < N_MBOX; i++) begin : g_word
    mbox_word #(.DW(DW)) u_word (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (set_sel[i]),
      .clr_i   (clr_sel[i]),
      .wdata_i (wdata_i),
      .q_o     (mbox_flat[i*DW +: DW]),
      .nz_o    (nz[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < N_CORES; c++) ctrl_q[c] <= '0;
    end else begin
      for (int c = 0; c < N_CORES; c++)
        if (ctrl_sel[c]) ctrl_q[c] <= wdata_i[CW-1:0];
    end
  end

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    assign ctrl_flat[c*CW +: CW] = ctrl_q[c];

    mbox_steer #(.M(M)) u_steer (
      .nz_i      (nz[c*M +: M]),
      .ctrl_i    (ctrl_q[c]),
      .irq_req_o (irq_req_o[c*M +: M]),
      .fiq_req_o (fiq_req_o[c*M +: M]),
      .irq_o     (irq_o[c]),
      .fiq_o     (fiq_o[c])
    );
  end

  always_comb begin
    unique case (rd_kind)
      RD_CTRL: rd_d = DW'(ctrl_q[core_idx]);
      RD_MBOX: rd_d = mbox_flat[mbox_idx*DW +: DW];
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= rd_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/mbox_bank_chk.sv
module mbox_bank_chk #(
  parameter int unsigned N_CORES = mbox_pkg::NUM_CORES,
  parameter int unsigned M       = mbox_pkg::MBOX_PER_CORE,
  parameter int unsigned DW      = mbox_pkg::DATA_W,
  parameter int unsigned AW      = mbox_pkg::ADDR_W
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      req_i,
  input logic                      we_i,
  input logic [AW-1:0]             addr_i,
  input logic [DW-1:0]             wdata_i,
  input logic [N_CORES*M*DW-1:0]   mbox_flat_i,
  input logic [N_CORES*2*M-1:0]    ctrl_flat_i,
  input logic [N_CORES*M-1:0]      irq_req_i,
  input logic [N_CORES*M-1:0]      fiq_req_i
);
  localparam int unsigned N_MBOX = N_CORES * M;
  localparam int unsigned CW     = 2 * M;
  localparam logic [31:0] CLR_END = mbox_pkg::CLR_BASE + 32'(4 * N_MBOX);

  logic [31:0] addr_ext;
  logic        clr_wr;
  assign addr_ext = 32'(addr_i);
  assign clr_wr   = req_i && we_i && (addr_ext >= mbox_pkg::CLR_BASE) && (addr_ext < CLR_END);

  // R7: FIQ request suppresses the IRQ request of the same word
  p_fiq_over_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_i & fiq_req_i) == '0);

  // R2: without an acknowledge write, no stored bit can fall
  p_set_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_wr |=> ((mbox_flat_i & $past(mbox_flat_i)) == $past(mbox_flat_i)));

  for (genvar i = 0; i < N_MBOX; i++) begin : g_word_chk
    // R9: a request needs a non-zero word
    p_req_needs_data_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_req_i[i] || fiq_req_i[i]) |-> (mbox_flat_i[i*DW +: DW] != '0));

    // R3: bits written as ones into the acknowledge window are gone next cycle
    p_clear_ones_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_wr && (addr_i[$clog2(N_MBOX)+1:2] == $clog2(N_MBOX)'(i)))
      |=> ((mbox_flat_i[i*DW +: DW] & $past(wdata_i)) == '0));
  end

  for (genvar c = 0; c < N_CORES; c++) begin : g_ctrl_chk
    // R6: steering write lands in the next cycle
    p_ctrl_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && (addr_ext == mbox_pkg::CTRL_BASE + 32'(4 * c)))
      |=> (ctrl_flat_i[c*CW +: CW] == $past(wdata_i[CW-1:0])));
  end
endmodule

bind mbox_bank mbox_bank_chk #(
  .N_CORES (N_CORES),
  .M       (M),
  .DW      (DW),
  .AW      (AW)
) i_mbox_bank_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .mbox_flat_i (mbox_flat),
  .ctrl_flat_i (ctrl_flat),
  .irq_req_i   (irq_req_o),
  .fiq_req_i   (fiq_req_o)
);

// File: tb/test_mbox_bank.sv
module test_mbox_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [15:0] irq_req_o, fiq_req_o;
  logic [3:0]  irq_o, fiq_o;

  int   n_chk = 0;
  int   n_fail = 0;
  logic done = 1'b0;

  // bench model, built from the requirements
  logic [31:0] m_mb [16];
  logic [7:0]  m_ctrl [4];

  always #5 clk_i = ~clk_i;

  mbox_bank i_mbox_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_req_o(irq_req_o), .fiq_req_o(fiq_req_o), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_fiq();
    logic [15:0] r = '0;
    for (int i = 0; i < 16; i++)
      r[i] = (m_mb[i] != 0) && m_ctrl[i/4][4 + i%4];
    return r;
  endfunction

  function automatic logic [15:0] exp_irq();
    logic [15:0] r = '0;
    for (int i = 0; i < 16; i++)
      r[i] = (m_mb[i] != 0) && m_ctrl[i/4][i%4] && !m_ctrl[i/4][4 + i%4];
    return r;
  endfunction

  task automatic chk_outs(input string tag);
    logic [15:0] ei, ef;
    logic [3:0]  oi, of;
    ei = exp_irq();
    ef = exp_fiq();
    for (int c = 0; c < 4; c++) begin
      oi[c] = |ei[c*4 +: 4];
      of[c] = |ef[c*4 +: 4];
    end
    chk({tag, " R8 irq_req"}, 32'(irq_req_o), 32'(ei));
    chk({tag, " R7 fiq_req"}, 32'(fiq_req_o), 32'(ef));
    chk({tag, " R10 irq_o"}, 32'(irq_o), 32'(oi));
    chk({tag, " R10 fiq_o"}, 32'(fiq_o), 32'(of));
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    if (a >= 8'h50 && a < 8'h60)      m_ctrl[(a - 8'h50) >> 2] = d[7:0];
    else if (a >= 8'h80 && a < 8'hC0) m_mb[(a - 8'h80) >> 2] |= d;
    else if (a >= 8'hC0)              m_mb[(a - 8'hC0) >> 2] &= ~d;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(posedge clk_i);
    @(negedge clk_i);
    d = rdata_o;
    req_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 rdata in reset", rdata_o, '0);
    chk("R1 irq_req in reset", 32'(irq_req_o), '0);
    chk("R1 fiq_req in reset", 32'(fiq_req_o), '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_outs("R1 after reset");
    for (int i = 0; i < 16; i++) begin
      rd(8'(8'hC0 + 4*i), d);
      chk("R1 word zero", d, '0);
    end
    for (int c = 0; c < 4; c++) begin
      rd(8'(8'h50 + 4*c), d);
      chk("R1 steering zero", d, '0);
    end
  endtask

  task automatic t_post_or();
    logic [31:0] d;
    wr(8'h94, 32'h0000_00F0);
    wr(8'h94, 32'h0000_0F00);
    rd(8'hD4, d);
    chk("R2 R4 OR of two posts", d, 32'h0000_0FF0);
    rd(8'hD0, d);
    chk("R2 neighbour below untouched", d, '0);
    rd(8'hD8, d);
    chk("R2 neighbour above untouched", d, '0);
    wr(8'hBC, 32'h8000_0001);
    rd(8'hFC, d);
    chk("R2 R4 last word", d, 32'h8000_0001);
  endtask

  task automatic t_ack_clear();
    logic [31:0] d;
    wr(8'hD4, 32'h0000_0030);
    rd(8'hD4, d);
    chk("R3 partial clear", d, 32'h0000_0FC0);
    wr(8'hD4, 32'h0000_0000);
    rd(8'hD4, d);
    chk("R3 zero write clears nothing", d, 32'h0000_0FC0);
    rd(8'h00, d);
    chk("R4 rdata holds until next read", 32'(rdata_o), d);
  endtask

  task automatic t_post_read_zero();
    logic [31:0] d;
    rd(8'h94, d);
    chk("R5 posting window reads zero", d, '0);
    rd(8'hBC, d);
    chk("R5 posting window last reads zero", d, '0);
  endtask

  task automatic t_steering_reg();
    logic [31:0] d;
    wr(8'h58, 32'hABCD_1234);
    rd(8'h58, d);
    chk("R6 low byte stored", d, 32'h0000_0034);
    wr(8'h58, 32'h0000_0000);
    rd(8'h58, d);
    chk("R6 cleared", d, '0);
  endtask

  task automatic t_steer();
    wr(8'h54, 32'h02);
    chk_outs("R8 irq only");
    chk("R8 irq_req bit 5", 32'(irq_req_o[5]), 32'd1);
    wr(8'h54, 32'h22);
    chk_outs("R7 both enables");
    chk("R7 fiq wins", 32'({irq_req_o[5], fiq_req_o[5]}), 32'b01);
    wr(8'h54, 32'h00);
    chk_outs("R9 enables clear");
    chk("R9 no request", 32'(irq_req_o | fiq_req_o), '0);
    wr(8'h54, 32'h11);
    chk_outs("R9 other word enabled only");
    wr(8'h54, 32'h02);
    wr(8'hD4, 32'hFFFF_FFFF);
    chk_outs("R9 word cleared");
    chk("R9 zero word no irq", 32'(irq_o[1]), '0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h4C, 32'hFFFF_FFFF);
    wr(8'h60, 32'hFFFF_FFFF);
    wr(8'h7C, 32'hFFFF_FFFF);
    chk_outs("R11 after stray writes");
    for (int c = 0; c < 4; c++) begin
      rd(8'(8'h50 + 4*c), d);
      chk("R11 steering unchanged", d, 32'(m_ctrl[c]));
    end
    rd(8'hFC, d);
    chk("R11 word unchanged", d, m_mb[15]);
    rd(8'h60, d);
    chk("R11 unmapped read zero", d, '0);
  endtask

  task automatic t_sweep();
    for (int c = 0; c < 4; c++) wr(8'(8'h50 + 4*c), 32'h0F);
    for (int i = 0; i < 16; i++) begin
      wr(8'(8'h80 + 4*i), 32'(1) << i);
      chk_outs("R2 R8 sweep");
    end
    wr(8'h5C, 32'hF0);
    chk_outs("R7 core3 fast");
    chk("R10 fiq_o core3 only", 32'(fiq_o), 32'h8);
    for (int i = 0; i < 16; i++) wr(8'(8'hC0 + 4*i), 32'hFFFF_FFFF);
    chk_outs("R3 R9 all cleared");
    chk("R9 nothing pending", 32'({irq_o, fiq_o}), '0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_mb[i] = '0;
    for (int c = 0; c < 4; c++) m_ctrl[c] = '0;
    repeat (3) @(negedge clk_i);
    t_reset();
    t_post_or();
    t_ack_clear();
    t_post_read_zero();
    t_steering_reg();
    t_steer();
    t_unmapped();
    t_sweep();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all requirements act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule